// File: doc/BRIEF.md
# Bus Hang Timeout Snapshot Monitor

This block watches a group of bus ports and raises a sticky flag when activity stays outstanding for longer than a programmed limit. Each port presents a busy flag and a 32-bit debug word. When the limit is reached, the block copies every port's debug word and a Gray-coded timestamp into registers. These registers then stay frozen, so the state of the interconnect at the moment of the hang survives a warm restart of the chip. Software can read it back afterwards.

Hang time is counted in blocks of 1024 clock cycles, behind a 10-bit prescaler. Software can mask individual ports out of detection, choose whether the hang must be continuous or may accumulate, and release the captured state only through an explicit clear that also needs the debug clock enable. A 32-bit register interface in the style of APB holds the control word, the mask, the captured timestamp and the captured debug words.

Top module: `bus_hang_snapshot`

## Requirements
- R1: After power-on reset, the control word (offset 0x000) reads 0, `hang_flag` is 0, and every captured debug word and timestamp word reads 0.
- R2: With threshold N in control bits 31:16 and the monitor enabled (bit 2), `hang_flag` and control bit 0 go high exactly after (N+1)*1024 consecutive clock cycles in which an unmasked port is busy, and not one cycle earlier.
- R3: With the hang type bit (control bit 1) at 0, one cycle in which every unmasked port is idle sets the hang count back to zero.
- R4: With the hang type bit at 1, busy cycles accumulate across idle gaps, and the flag rises once the total reaches (N+1)*1024.
- R5: Bit i of the mask register at offset 0x004 removes port i from detection. A busy port whose bit is set never advances the count.
- R6: On the cycle the flag rises, each port i's debug word is captured at offset 0x408+4*i. The same cycle captures the Gray-coded 64-bit free-running timestamp, low word at 0x400 and high word at 0x404. The captured values do not change while the flag stays high.
- R7: A pulse on `warm_rst_n` clears the enable bit and the hang counters. It leaves the flag and all captured words unchanged.
- R8: When control bit 9 (clear) is written as 1 together with bit 3 (debug clock enable) as 1, the flag and all captured words return to 0. When clear is written with bit 3 at 0, nothing is cleared.
- R9: A threshold of 0xFFFF never raises the flag.
- R10: While the enable bit is 0, busy ports never raise the flag.
- R11: The timestamp advances by one every clock cycle, so two captures that are K cycles apart decode from Gray to binary values that differ by K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; asserts asynchronously and releases synchronously |
| warm_rst_n | input | 1 | Warm (watchdog) reset, active low, synchronous |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| port_busy | input | NUM_PORTS | Per-port outstanding-activity flag |
| port_dbg | input | NUM_PORTS*32 | Per-port debug words, port i in bits 32*i+31:32*i |
| hang_flag | output | 1 | Sticky timeout flag |

## Verification
The assertions take for granted that `warm_rst_n`, `port_busy` and `port_dbg` are synchronous to `clk`. They also assume that control and mask writes only take place while the block is not counting. The bench changes all of these inputs on the falling edge. It always runs the bring-up order with the busy flags low: mask, clear with the clock enable, release of the clear, threshold and type, and enable last.

// File: rtl/hang_pkg.sv
package hang_pkg;
  localparam int unsigned DBG_W      = 32;
  localparam int unsigned PRE_W      = 10;
  localparam int unsigned THR_W      = 16;
  localparam int unsigned TS_W       = 64;
  localparam logic [THR_W-1:0] THR_NEVER = '1;

  localparam int unsigned B_FLAG  = 0;
  localparam int unsigned B_TYPE  = 1;
  localparam int unsigned B_EN    = 2;
  localparam int unsigned B_CKEN  = 3;
  localparam int unsigned B_CLR   = 9;
  localparam int unsigned B_THR   = 16;

  localparam int unsigned W_CTRL  = 'h000;
  localparam int unsigned W_MASK  = 'h001;
  localparam int unsigned W_TS_LO = 'h100;
  localparam int unsigned W_TS_HI = 'h101;
  localparam int unsigned W_DBG0  = 'h102;

  function automatic logic [TS_W-1:0] bin2gray(input logic [TS_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/hang_rst_sync.sv
module hang_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hang_timer.sv
module hang_timer
  import hang_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_clr,
  input  logic             sw_clr,
  input  logic             en,
  input  logic             accum,
  input  logic [THR_W-1:0] thres,
  input  logic             hit,
  input  logic             frozen,
  output logic             fire
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [THR_W-1:0] unit_q, unit_d;
  logic             active, wrap, at_thr;

  assign active = en & hit & ~frozen;
  assign wrap   = (pre_q == PRE_LAST);
  assign at_thr = (unit_q == thres);
  assign fire   = active & wrap & at_thr & (thres != THR_NEVER);

  always_comb begin
    pre_d  = pre_q;
    unit_d = unit_q;
    if (warm_clr || sw_clr) begin
      pre_d  = '0;
      unit_d = '0;
    end else if (active) begin
      pre_d = pre_q + 1'b1;
      if (wrap && !at_thr) unit_d = unit_q + 1'b1;
    end else if (!accum && (!hit || !en)) begin
      pre_d  = '0;
      unit_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else begin
      pre_q  <= pre_d;
      unit_q <= unit_d;
    end
  end
endmodule

// File: rtl/hang_capture.sv
module hang_capture
  import hang_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fire,
  input  logic                       sw_clr,
  input  logic [NUM_PORTS*DBG_W-1:0] dbg_in,
  input  logic [TS_W-1:0]            ts_gray,
  output logic [NUM_PORTS*DBG_W-1:0] dbg_cap,
  output logic [TS_W-1:0]            ts_cap
);
  logic [TS_W-1:0] ts_d;

  always_comb begin
    ts_d = ts_cap;
    if (sw_clr)    ts_d = '0;
    else if (fire) ts_d = ts_gray;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_cap <= '0;
    else        ts_cap <= ts_d;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [DBG_W-1:0] word_d;
    always_comb begin
      word_d = dbg_cap[i*DBG_W +: DBG_W];
      if (sw_clr)    word_d = '0;
      else if (fire) word_d = dbg_in[i*DBG_W +: DBG_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dbg_cap[i*DBG_W +: DBG_W] <= '0;
      else        dbg_cap[i*DBG_W +: DBG_W] <= word_d;
    end
  end
endmodule

// File: rtl/bus_hang_snapshot.sv
module bus_hang_snapshot
  import hang_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       warm_rst_n,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [31:0]                pwdata,
  output logic [31:0]                prdata,
  input  logic [NUM_PORTS-1:0]       port_busy,
  input  logic [NUM_PORTS*DBG_W-1:0] port_dbg,
  output logic                       hang_flag
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic rst_n;
  hang_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .arst_n(por_n), .rst_n(rst_n));

  logic [WIDX_W-1:0] widx;
  logic              aligned, wr_ctrl, wr_mask;
  assign widx    = paddr[ADDR_W-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wr_ctrl = psel & penable & pwrite & aligned & (widx == WIDX_W'(W_CTRL));
  assign wr_mask = psel & penable & pwrite & aligned & (widx == WIDX_W'(W_MASK));

  logic             en_q, type_q, cken_q, clr_q, flag_q;
  logic             en_d, type_d, cken_d, clr_d, flag_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic [NUM_PORTS-1:0] mask_q, mask_d;
  logic             sw_clr, warm_clr, fire, hit;

  assign sw_clr   = clr_q & cken_q;
  assign warm_clr = ~warm_rst_n;
  assign hit      = |(port_busy & ~mask_q);

  always_comb begin
    en_d   = en_q;
    type_d = type_q;
    cken_d = cken_q;
    clr_d  = clr_q;
    thr_d  = thr_q;
    mask_d = mask_q;
    flag_d = flag_q;
    if (wr_ctrl) begin
      en_d   = pwdata[B_EN];
      type_d = pwdata[B_TYPE];
      cken_d = pwdata[B_CKEN];
      clr_d  = pwdata[B_CLR];
      thr_d  = pwdata[B_THR +: THR_W];
    end
    if (wr_mask) mask_d = pwdata[NUM_PORTS-1:0];
    if (warm_clr) en_d = 1'b0;
    if (sw_clr)    flag_d = 1'b0;
    else if (fire) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      type_q <= 1'b0;
      cken_q <= 1'b0;
      clr_q  <= 1'b0;
      flag_q <= 1'b0;
      thr_q  <= '0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      type_q <= type_d;
      cken_q <= cken_d;
      clr_q  <= clr_d;
      flag_q <= flag_d;
      thr_q  <= thr_d;
      mask_q <= mask_d;
    end
  end

  logic [TS_W-1:0] ts_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  hang_timer u_timer (
    .clk(clk), .rst_n(rst_n), .warm_clr(warm_clr), .sw_clr(sw_clr),
    .en(en_q), .accum(type_q), .thres(thr_q), .hit(hit),
    .frozen(flag_q), .fire(fire)
  );

  logic [NUM_PORTS*DBG_W-1:0] dbg_cap;
  logic [TS_W-1:0]            ts_cap;
  hang_capture #(.NUM_PORTS(NUM_PORTS)) u_cap (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sw_clr(sw_clr),
    .dbg_in(port_dbg), .ts_gray(bin2gray(ts_q)),
    .dbg_cap(dbg_cap), .ts_cap(ts_cap)
  );

  always_comb begin
    prdata = '0;
    if (psel && aligned) begin
      if (widx == WIDX_W'(W_CTRL)) begin
        prdata[B_FLAG]          = flag_q;
        prdata[B_TYPE]          = type_q;
        prdata[B_EN]            = en_q;
        prdata[B_CKEN]          = cken_q;
        prdata[B_CLR]           = clr_q;
        prdata[B_THR +: THR_W]  = thr_q;
      end else if (widx == WIDX_W'(W_MASK)) begin
        prdata[NUM_PORTS-1:0] = mask_q;
      end else if (widx == WIDX_W'(W_TS_LO)) begin
        prdata = ts_cap[31:0];
      end else if (widx == WIDX_W'(W_TS_HI)) begin
        prdata = ts_cap[63:32];
      end
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (widx == WIDX_W'(W_DBG0 + i)) prdata = dbg_cap[i*DBG_W +: DBG_W];
      end
    end
  end

  assign hang_flag = flag_q;
endmodule

// File: rtl/hang_snapshot_checker.sv
module hang_snapshot_checker
  import hang_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flag,
  input logic                       en,
  input logic                       sw_clr,
  input logic [THR_W-1:0]           thres,
  input logic [NUM_PORTS-1:0]       busy,
  input logic [NUM_PORTS-1:0]       mask,
  input logic [NUM_PORTS*DBG_W-1:0] dbg_cap,
  input logic [TS_W-1:0]            ts_cap
);
  a_r10_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en));

  a_r5_rise_needs_unmasked_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(|(busy & ~mask)));

  a_r9_never_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(thres) != THR_NEVER);

  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !flag);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sw_clr) |=> flag);

  a_r6_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !sw_clr) |=> ($stable(dbg_cap) && $stable(ts_cap)));
endmodule

bind bus_hang_snapshot hang_snapshot_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag(flag_q), .en(en_q), .sw_clr(sw_clr),
  .thres(thr_q), .busy(port_busy), .mask(mask_q),
  .dbg_cap(dbg_cap), .ts_cap(ts_cap)
);

// File: tb/tb_bus_hang_snapshot.sv
module tb_bus_hang_snapshot;
  localparam int NP = 4;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic por_n, warm_rst_n, psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [NP-1:0] port_busy;
  logic [NP*32-1:0] port_dbg;
  logic hang_flag;
  int errors = 0, checks = 0;
  longint cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_hang_snapshot #(.NUM_PORTS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .port_busy(port_busy), .port_dbg(port_dbg),
    .hang_flag(hang_flag));

  // {thres[47:32], mask[31:28], busy[27:24], cycles[23:8], expect[0]}
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 4'h0, 4'h1, 16'd1023, 7'd0, 1'b0},   // R2 one short
    {16'h0000, 4'h0, 4'h1, 16'd1024, 7'd0, 1'b1},   // R2 exact
    {16'h0001, 4'h0, 4'h2, 16'd2047, 7'd0, 1'b0},   // R2 N=1 short
    {16'h0001, 4'h0, 4'h2, 16'd2048, 7'd0, 1'b1},   // R2 N=1 exact
    {16'h0000, 4'h1, 4'h1, 16'd3000, 7'd0, 1'b0},   // R5 masked only
    {16'h0000, 4'h1, 4'h3, 16'd1024, 7'd0, 1'b1},   // R5 unmasked port
    {16'hFFFF, 4'h0, 4'hF, 16'd3000, 7'd0, 1'b0}    // R9
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    #1 d = prdata;
    @(negedge clk); psel = 0;
  endtask

  task automatic bring_up(input logic [15:0] thr, input logic typ, input logic [NP-1:0] m);
    apb_wr('h004, 32'(m));
    apb_wr('h000, 32'h0000_0208);
    apb_wr('h000, 32'h0000_0008);
    apb_wr('h000, {thr, 14'd0, typ, 1'b0} | 32'h8);
    apb_wr('h000, {thr, 14'd0, typ, 1'b0} | 32'hC);
  endtask

  task automatic run_busy(input logic [NP-1:0] b, input int n);
    @(negedge clk); port_busy = b;
    repeat (n) @(posedge clk);
    @(negedge clk); port_busy = '0;
  endtask

  function automatic logic [63:0] gray2bin(input logic [63:0] g);
    logic [63:0] b;
    b[63] = g[63];
    for (int k = 62; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd, lo, hi;
    logic [63:0] d1, d2;
    longint a1, a2;
    por_n = 0; warm_rst_n = 1; psel = 0; penable = 0; pwrite = 0;
    paddr = '0; pwdata = '0; port_busy = '0;
    for (int i = 0; i < NP; i++) port_dbg[i*32 +: 32] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    por_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    apb_rd('h000, rd); check("R1 ctrl", rd, 0);
    check("R1 flag", hang_flag, 0);
    apb_rd('h400, rd); check("R1 ts lo", rd, 0);
    apb_rd('h408, rd); check("R1 dbg0", rd, 0);

    // Vector table: R2, R5, R9
    for (int v = 0; v < NV; v++) begin
      bring_up(VEC[v][47:32], 1'b0, VEC[v][31:28]);
      run_busy(VEC[v][27:24], int'(VEC[v][23:8]));
      check($sformatf("R2/R5/R9 vec%0d flag", v), hang_flag, VEC[v][0]);
    end

    // R6 capture and freeze
    bring_up(16'h0, 1'b0, '0);
    run_busy(4'h8, 1024);
    check("R6 flag", hang_flag, 1);
    for (int i = 0; i < NP; i++) port_dbg[i*32 +: 32] = 32'h5555_0000 + i;
    run_busy(4'hF, 50);
    for (int i = 0; i < NP; i++) begin
      apb_rd(AW'('h408 + 4*i), rd);
      check($sformatf("R6 dbg%0d frozen", i), rd, 32'hA000_0000 + i);
    end

    // R7 warm reset keeps flag and captures, clears enable
    @(negedge clk); warm_rst_n = 0;
    @(negedge clk); warm_rst_n = 1;
    apb_rd('h000, rd);
    check("R7 flag bit", rd[0], 1);
    check("R7 enable bit", rd[2], 0);
    apb_rd('h40C, rd); check("R7 dbg1 kept", rd, 32'hA000_0001);

    // R8 clear without clock enable has no effect
    apb_wr('h000, 32'h0000_0200);
    apb_wr('h000, 32'h0000_0000);
    check("R8 no-cken flag", hang_flag, 1);
    apb_rd('h408, rd); check("R8 no-cken dbg0", rd, 32'hA000_0000);
    apb_wr('h000, 32'h0000_0208);
    apb_wr('h000, 32'h0000_0008);
    check("R8 cleared flag", hang_flag, 0);
    apb_rd('h408, rd); check("R8 cleared dbg0", rd, 0);
    apb_rd('h404, rd); check("R8 cleared ts hi", rd, 0);

    // R11 timestamp advance between two captures
    bring_up(16'h0, 1'b0, '0);
    run_busy(4'h1, 1024);
    a1 = cyc;
    apb_rd('h400, lo); apb_rd('h404, hi); d1 = gray2bin({hi, lo});
    repeat (37) @(negedge clk);
    bring_up(16'h0, 1'b0, '0);
    run_busy(4'h1, 1024);
    a2 = cyc;
    apb_rd('h400, lo); apb_rd('h404, hi); d2 = gray2bin({hi, lo});
    check("R11 ts delta", d2 - d1, 64'(a2 - a1));

    // R3 continuous type: idle gap restarts
    bring_up(16'h0, 1'b0, '0);
    run_busy(4'h1, 600);
    run_busy(4'h1, 600);
    check("R3 restart", hang_flag, 0);

    // R4 accumulate type
    bring_up(16'h0, 1'b1, '0);
    run_busy(4'h1, 600);
    repeat (5) @(negedge clk);
    run_busy(4'h1, 423);
    check("R4 one short", hang_flag, 0);
    run_busy(4'h1, 1);
    check("R4 total reached", hang_flag, 1);

    // R10 disabled monitor
    bring_up(16'h0, 1'b0, '0);
    apb_wr('h000, 32'h0000_0008);
    run_busy(4'hF, 2000);
    check("R10 disabled", hang_flag, 0);

    // R1 power-on reset clears a captured hang
    bring_up(16'h0, 1'b0, '0);
    run_busy(4'h1, 1024);
    check("R1 pre-por flag", hang_flag, 1);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    repeat (3) @(negedge clk);
    check("R1 por flag", hang_flag, 0);
    apb_rd('h408, rd); check("R1 por dbg0", rd, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule